// File: doc/BRIEF.md
# SD Data Path Timeout and Byte Counter

This unit sits beside the data path sequencer of an SD card host controller. A small register write port holds a 32-bit timeout period, counted in card bus clock periods, and a 25-bit transfer length in bytes. A later write to the control address starts a transfer. On that start the unit checks the stored length against the selected transfer mode. A legal length is copied into a byte counter. An illegal length raises a sticky configuration-error flag and no transfer starts.

During a transfer the byte counter counts down by the number of bytes reported on a per-cycle strobe. The done output is high while the transfer is active and the counter reads zero. Separately, a timeout counter watches the sequencer state. It reloads from the timeout register each time the sequencer moves into a waiting state, either waiting for read data to begin or waiting on card busy. It then counts down on each card clock enable. If it is zero while the sequencer is still waiting, the unit drives an abort and sets a sticky timeout flag. Software clears both flags with write-one-to-clear bits.

Top module: `sdDataTimer`

## Requirements
- R1: After reset every output is zero: both registers, both counters, the active and done outputs, both flags and the abort.
- R2: A write to address 0 loads the timeout register from all 32 data bits. A write to address 1 loads the length register from data bits 24:0, and bits 31:25 are dropped. The new values appear on timerVal and lengthVal after the clock edge that takes the write.
- R3: A write to address 2 with bit 0 set and a legal length starts a transfer. After that edge xferActive is 1 and bytesLeft equals lengthVal.
- R4: While a transfer is active, each cycle with byteStrobe high lowers bytesLeft by byteCnt and stops at zero. byteStrobe has no effect while no transfer is active.
- R5: done is high exactly while xferActive is 1 and bytesLeft is 0. The transfer ends at the next edge, so done lasts one cycle. A legal zero-length start raises done at once.
- R6: Control bit 1 = 0 selects block mode, with a block size of 2 to the power of control bits 5:2. In this mode a length that is not a whole multiple of the block size sets cfgErrFlag and starts no transfer. Zero counts as a multiple.
- R7: Control bit 1 = 1 selects multibyte mode. In this mode a length outside 1 to 512 sets cfgErrFlag and starts no transfer.
- R8: The sequencer state on dpState is 0 idle, 1 waiting for read data, 2 card busy, and 3 other. On any edge where dpState is 1 or 2 and differs from its value at the previous edge, timeLeft is loaded from timerVal. This includes a move from 1 to 2.
- R9: timeLeft falls by one on each edge where the state is waiting, the state was not just entered, clkEn is high and timeLeft is nonzero. It holds its value on every other edge. abortOut is low whenever dpState is 0 or 3.
- R10: abortOut is high while dpState is 1 or 2, the state was not just entered, and timeLeft is zero. The edge after that sets timeoutFlag. timeoutFlag stays set until it is cleared.
- R11: A write to address 3 clears timeoutFlag if data bit 0 is set and clears cfgErrFlag if data bit 1 is set. If a flag's set condition occurs in the same cycle as its clear, the set wins.
- R12: Writing the length register during a transfer leaves bytesLeft unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 2 | Write address: 0 timeout, 1 length, 2 control, 3 flag clear |
| regWrData | input | 32 | Write data |
| dpState | input | 2 | Sequencer state: 0 idle, 1 wait for read, 2 busy, 3 other |
| clkEn | input | 1 | Card bus clock enable pulse |
| byteStrobe | input | 1 | Bytes moved this cycle |
| byteCnt | input | 3 | Number of bytes moved this cycle |
| timerVal | output | 32 | Timeout register |
| lengthVal | output | 25 | Length register |
| timeLeft | output | 32 | Timeout counter |
| bytesLeft | output | 25 | Byte counter |
| xferActive | output | 1 | Transfer in progress |
| done | output | 1 | Byte counter reached zero |
| timeoutFlag | output | 1 | Sticky timeout flag |
| cfgErrFlag | output | 1 | Sticky illegal-length flag |
| abortOut | output | 1 | Abort request to the sequencer |

## Verification
The case that needs care is a timeout expiry and a software clear of the timeout flag landing in the same cycle. The bench sets up this race on purpose. It loads a zero period and enters the busy state, which raises the abort. It then issues the clear write on the very edge at which the expiry sets the flag. The flag must read 1 after that edge. A second clear, made once the sequencer is idle, must bring it to 0. Expiry cycles for a sweep of periods and the legality of every length and block-size pair in a small range are computed arithmetically in the bench.

// File: rtl/sdDtPkg.sv
package sdDtPkg;
  localparam logic [1:0] ADDR_TIMER = 2'd0;
  localparam logic [1:0] ADDR_LEN   = 2'd1;
  localparam logic [1:0] ADDR_CTRL  = 2'd2;
  localparam logic [1:0] ADDR_CLR   = 2'd3;

  localparam logic [1:0] DP_IDLE  = 2'd0;
  localparam logic [1:0] DP_WAITR = 2'd1;
  localparam logic [1:0] DP_BUSY  = 2'd2;

  typedef struct packed {
    logic wrTimer;
    logic wrLength;
    logic start;
    logic decBytes;
    logic loadTimer;
    logic decTimer;
    logic setTimeout;
    logic clrTimeout;
    logic setCfgErr;
    logic clrCfgErr;
  } dtStrobe_t;
endpackage

// File: rtl/sdDtCtrl.sv
module sdDtCtrl
  import sdDtPkg::*;
#(
  parameter int LEN_W     = 25,
  parameter int BSZ_W     = 4,
  parameter int MULTI_MAX = 512,
  localparam int CF_W     = 2 + BSZ_W
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             regWrEn,
  input  logic [1:0]       regAddr,
  input  logic [CF_W-1:0]  ctrlField,
  input  logic [1:0]       dpState,
  input  logic             clkEn,
  input  logic             byteStrobe,
  input  logic [LEN_W-1:0] lengthVal,
  input  logic             timerZero,
  output dtStrobe_t        strb,
  output logic             abortOut
);
  logic [1:0] prevState;
  logic waiting, entering, expire;
  logic ctrlStart, clrWr, legal, blockOk, multiOk;
  logic [BSZ_W-1:0] bsLog;
  logic [LEN_W-1:0] bsMask;

  always_ff @(posedge clk) begin
    if (!rstN) prevState <= DP_IDLE;
    else       prevState <= dpState;
  end

  always_comb begin
    waiting  = (dpState == DP_WAITR) || (dpState == DP_BUSY);
    entering = waiting && (dpState != prevState);
    expire   = waiting && !entering && timerZero;

    bsLog   = ctrlField[2+BSZ_W-1:2];
    bsMask  = (LEN_W'(1) << bsLog) - LEN_W'(1);
    blockOk = (lengthVal & bsMask) == '0;
    multiOk = (lengthVal != '0) && (lengthVal <= LEN_W'(MULTI_MAX));
    legal   = ctrlField[1] ? multiOk : blockOk;

    ctrlStart = regWrEn && (regAddr == ADDR_CTRL) && ctrlField[0];
    clrWr     = regWrEn && (regAddr == ADDR_CLR);

    strb            = '0;
    strb.wrTimer    = regWrEn && (regAddr == ADDR_TIMER);
    strb.wrLength   = regWrEn && (regAddr == ADDR_LEN);
    strb.start      = ctrlStart && legal;
    strb.setCfgErr  = ctrlStart && !legal;
    strb.decBytes   = byteStrobe && !strb.start;
    strb.loadTimer  = entering;
    strb.decTimer   = waiting && !entering && clkEn && !timerZero;
    strb.setTimeout = expire;
    strb.clrTimeout = clrWr && ctrlField[0];
    strb.clrCfgErr  = clrWr && ctrlField[1];
    abortOut        = expire;
  end
endmodule

// File: rtl/sdDtPath.sv
module sdDtPath
  import sdDtPkg::*;
#(
  parameter int DATA_W  = 32,
  parameter int TIMER_W = 32,
  parameter int LEN_W   = 25,
  parameter int CNT_W   = 3
) (
  input  logic               clk,
  input  logic               rstN,
  input  dtStrobe_t          strb,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [CNT_W-1:0]   byteCnt,
  output logic [TIMER_W-1:0] timerVal,
  output logic [LEN_W-1:0]   lengthVal,
  output logic [TIMER_W-1:0] timeLeft,
  output logic [LEN_W-1:0]   bytesLeft,
  output logic               xferActive,
  output logic               done,
  output logic               timeoutFlag,
  output logic               cfgErrFlag,
  output logic               timerZero
);
  logic [LEN_W-1:0] stepBytes, nextBytes;

  always_comb begin
    stepBytes = {{(LEN_W-CNT_W){1'b0}}, byteCnt};
    nextBytes = (bytesLeft > stepBytes) ? bytesLeft - stepBytes : '0;
    done      = xferActive && (bytesLeft == '0);
    timerZero = (timeLeft == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      timerVal    <= '0;
      lengthVal   <= '0;
      timeLeft    <= '0;
      bytesLeft   <= '0;
      xferActive  <= 1'b0;
      timeoutFlag <= 1'b0;
      cfgErrFlag  <= 1'b0;
    end else begin
      if (strb.wrTimer)  timerVal  <= regWrData[TIMER_W-1:0];
      if (strb.wrLength) lengthVal <= regWrData[LEN_W-1:0];

      if (strb.loadTimer)     timeLeft <= timerVal;
      else if (strb.decTimer) timeLeft <= timeLeft - TIMER_W'(1);

      if (strb.start) begin
        xferActive <= 1'b1;
        bytesLeft  <= lengthVal;
      end else if (done) begin
        xferActive <= 1'b0;
      end else if (xferActive && strb.decBytes) begin
        bytesLeft <= nextBytes;
      end

      timeoutFlag <= strb.setTimeout | (timeoutFlag & ~strb.clrTimeout);
      cfgErrFlag  <= strb.setCfgErr  | (cfgErrFlag  & ~strb.clrCfgErr);
    end
  end
endmodule

// File: rtl/sdDataTimer.sv
module sdDataTimer
  import sdDtPkg::*;
#(
  parameter int DATA_W    = 32,
  parameter int TIMER_W   = 32,
  parameter int LEN_W     = 25,
  parameter int CNT_W     = 3,
  parameter int BSZ_W     = 4,
  parameter int MULTI_MAX = 512
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [1:0]         regAddr,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic [1:0]         dpState,
  input  logic               clkEn,
  input  logic               byteStrobe,
  input  logic [CNT_W-1:0]   byteCnt,
  output logic [TIMER_W-1:0] timerVal,
  output logic [LEN_W-1:0]   lengthVal,
  output logic [TIMER_W-1:0] timeLeft,
  output logic [LEN_W-1:0]   bytesLeft,
  output logic               xferActive,
  output logic               done,
  output logic               timeoutFlag,
  output logic               cfgErrFlag,
  output logic               abortOut
);
  dtStrobe_t strb;
  logic timerZero;

  sdDtCtrl #(.LEN_W(LEN_W), .BSZ_W(BSZ_W), .MULTI_MAX(MULTI_MAX)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .ctrlField(regWrData[2+BSZ_W-1:0]), .dpState(dpState), .clkEn(clkEn),
    .byteStrobe(byteStrobe), .lengthVal(lengthVal), .timerZero(timerZero),
    .strb(strb), .abortOut(abortOut)
  );

  sdDtPath #(.DATA_W(DATA_W), .TIMER_W(TIMER_W), .LEN_W(LEN_W), .CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .strb(strb), .regWrData(regWrData), .byteCnt(byteCnt),
    .timerVal(timerVal), .lengthVal(lengthVal), .timeLeft(timeLeft),
    .bytesLeft(bytesLeft), .xferActive(xferActive), .done(done),
    .timeoutFlag(timeoutFlag), .cfgErrFlag(cfgErrFlag), .timerZero(timerZero)
  );
endmodule

// File: rtl/sdDtChecker.sv
module sdDtChecker #(
  parameter int TIMER_W = 32,
  parameter int LEN_W   = 25
) (
  input logic               clk,
  input logic               rstN,
  input logic               regWrEn,
  input logic [1:0]         regAddr,
  input logic [1:0]         ctrlLow,
  input logic [1:0]         dpState,
  input logic [TIMER_W-1:0] timeLeft,
  input logic [LEN_W-1:0]   lengthVal,
  input logic [LEN_W-1:0]   bytesLeft,
  input logic               xferActive,
  input logic               done,
  input logic               timeoutFlag,
  input logic               cfgErrFlag,
  input logic               abortOut
);
  logic ctrlWr, waitSt;
  assign ctrlWr = regWrEn && (regAddr == 2'd2);
  assign waitSt = (dpState == 2'd1) || (dpState == 2'd2);

  p_abort_sets_flag_r10: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |=> timeoutFlag);

  p_flag_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    timeoutFlag && !(regWrEn && regAddr == 2'd3 && ctrlLow[0]) |=> timeoutFlag);

  p_abort_only_waiting_r9: assert property (@(posedge clk) disable iff (!rstN)
    abortOut |-> waitSt);

  p_timer_frozen_r9: assert property (@(posedge clk) disable iff (!rstN)
    !waitSt |=> $stable(timeLeft));

  p_bytes_no_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    xferActive && !ctrlWr |=> bytesLeft <= $past(bytesLeft));

  p_done_ends_r5: assert property (@(posedge clk) disable iff (!rstN)
    done && !ctrlWr |=> !xferActive);

  p_multi_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctrlWr && ctrlLow == 2'b11 && lengthVal == '0 |=> cfgErrFlag);
endmodule

bind sdDataTimer sdDtChecker #(.TIMER_W(TIMER_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .ctrlLow(regWrData[1:0]), .dpState(dpState), .timeLeft(timeLeft),
  .lengthVal(lengthVal), .bytesLeft(bytesLeft), .xferActive(xferActive),
  .done(done), .timeoutFlag(timeoutFlag), .cfgErrFlag(cfgErrFlag),
  .abortOut(abortOut)
);

// File: tb/tb_sdDataTimer.sv
`timescale 1ns/1ps
module tb_sdDataTimer;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [1:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [1:0] dpState = '0;
  logic clkEn = 1'b0;
  logic byteStrobe = 1'b0;
  logic [2:0] byteCnt = '0;
  logic [31:0] timerVal, timeLeft;
  logic [24:0] lengthVal, bytesLeft;
  logic xferActive, done, timeoutFlag, cfgErrFlag, abortOut;
  int nChk = 0;
  int nFail = 0;

  always #4 clk = ~clk;

  sdDataTimer dut (.*);

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string req, longint act, longint exp);
    nChk++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    tick();
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic drain(int len);
    int expLeft = len;
    int cyc = 0;
    while (1) begin
      if (expLeft == 0) begin
        chk("R5 done at zero", done, 1);
        tick();
        chk("R5 transfer ends", xferActive, 0);
        chk("R5 done one cycle", done, 0);
        break;
      end
      chk("R5 done low", done, 0);
      byteStrobe = 1'b1;
      byteCnt = 3'((cyc % 5) + 1);
      tick();
      expLeft = (expLeft > int'(byteCnt)) ? expLeft - int'(byteCnt) : 0;
      chk("R4 countdown", bytesLeft, expLeft);
      byteStrobe = 1'b0;
      cyc++;
    end
  endtask

  initial begin
    #(8 * 200000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end

  initial begin
    repeat (3) tick();
    chk("R1 timerVal", timerVal, 0);
    chk("R1 lengthVal", lengthVal, 0);
    chk("R1 timeLeft", timeLeft, 0);
    chk("R1 bytesLeft", bytesLeft, 0);
    chk("R1 active", xferActive, 0);
    chk("R1 done", done, 0);
    chk("R1 flags", {timeoutFlag, cfgErrFlag, abortOut}, 0);
    rstN = 1'b1;
    tick();

    // R2 register loads
    wr(0, 32'hA5A5_1234);
    chk("R2 timer", timerVal, 32'hA5A5_1234);
    wr(1, 32'hFFFF_FFFF);
    chk("R2 length reserved dropped", lengthVal, 25'h1FF_FFFF);

    // R8/R9/R10 expiry sweep
    clkEn = 1'b1;
    for (int n = 0; n <= 6; n++) begin
      wr(0, 32'(n));
      dpState = 2'd0; tick();
      dpState = (n % 2 == 0) ? 2'd1 : 2'd2;
      tick();
      chk("R8 load on entry", timeLeft, n);
      for (int k = 0; k < n; k++) begin
        chk("R10 no early abort", abortOut, 0);
        tick();
        chk("R9 decrement", timeLeft, n - k - 1);
      end
      chk("R10 abort at zero", abortOut, 1);
      tick();
      chk("R10 flag set", timeoutFlag, 1);
      dpState = 2'd0; tick();
      chk("R9 no abort when idle", abortOut, 0);
      chk("R10 flag sticky", timeoutFlag, 1);
      wr(3, 32'h1);
      chk("R11 clear timeout", timeoutFlag, 0);
    end

    // R9 freeze and R8 reload on wait->busy
    wr(0, 32'd10);
    dpState = 2'd0; tick();
    dpState = 2'd1; tick();
    chk("R8 load", timeLeft, 10);
    clkEn = 1'b0;
    repeat (4) tick();
    chk("R9 hold without enable", timeLeft, 10);
    clkEn = 1'b1;
    tick(); tick();
    chk("R9 count with enable", timeLeft, 8);
    dpState = 2'd2; tick();
    chk("R8 reload on busy", timeLeft, 10);
    tick();
    chk("R9 count busy", timeLeft, 9);
    dpState = 2'd3;
    repeat (3) tick();
    chk("R9 hold outside wait", timeLeft, 9);
    chk("R9 no abort other state", abortOut, 0);

    // R11 set beats clear in the same cycle
    wr(0, 32'd0);
    dpState = 2'd0; tick();
    dpState = 2'd2; tick();
    chk("R10 immediate abort", abortOut, 1);
    wr(3, 32'h1);
    chk("R11 set wins over clear", timeoutFlag, 1);
    dpState = 2'd0; tick();
    wr(3, 32'h1);
    chk("R11 clear after idle", timeoutFlag, 0);

    // R6 block legality sweep
    for (int bs = 0; bs <= 4; bs++) begin
      for (int len = 0; len <= 40; len++) begin
        bit bad;
        bad = (len % (1 << bs)) != 0;
        wr(1, 32'(len));
        wr(2, 32'(1 | (bs << 2)));
        chk("R6 block cfg error", cfgErrFlag, bad);
        chk("R3 start accepted", xferActive, !bad);
        if (!bad) begin
          chk("R3 counter loaded", bytesLeft, len);
          drain(len);
        end else begin
          wr(3, 32'h2);
          chk("R11 clear cfg error", cfgErrFlag, 0);
        end
      end
    end

    // R4 strobe ignored while idle
    byteStrobe = 1'b1; byteCnt = 3'd3;
    tick();
    byteStrobe = 1'b0;
    chk("R4 idle strobe ignored", bytesLeft, 0);
    chk("R4 idle stays idle", xferActive, 0);

    // R7 multibyte window
    begin
      int lens[9] = '{0, 1, 2, 7, 100, 511, 512, 513, 4096};
      foreach (lens[i]) begin
        bit bad;
        bad = (lens[i] < 1) || (lens[i] > 512);
        wr(1, 32'(lens[i]));
        wr(2, 32'h3);
        chk("R7 multibyte cfg error", cfgErrFlag, bad);
        chk("R7 start accepted", xferActive, !bad);
        if (!bad) drain(lens[i]);
        else wr(3, 32'h2);
      end
    end

    // R12 length write during transfer
    wr(1, 32'd20);
    wr(2, 32'h1);
    byteStrobe = 1'b1; byteCnt = 3'd4;
    tick();
    byteStrobe = 1'b0;
    chk("R4 strobe step", bytesLeft, 16);
    wr(1, 32'd999);
    chk("R12 count untouched", bytesLeft, 16);
    chk("R2 length updated", lengthVal, 999);
    drain(16);

    $display("== %0d vectors applied, %0d miscompares ==", nChk, nFail);
    $finish;
  end
endmodule